// File: doc/BRIEF.md
# Watchdog Interval Timer

This block counts cycles of the main system clock and serves one of two roles. In interval role it raises a one-cycle maskable interrupt pulse every time a chosen power-of-two period elapses, then continues into the next period without any software action. In watchdog role the same count raises a one-cycle overflow event instead, unless software restarts the period first. Once the watchdog role has been chosen it stays in force until reset.

Software drives it through a write strobe that carries three fields together: a role bit, a three-bit period select and a restart bit. The count is built from a free-running prescaler followed by a main counter. A restart clears only the main counter, so the first period after a restart can be shorter than nominal by up to one prescaler cycle. The count keeps running in halt. It freezes and keeps its value while idle or stop is requested, or while the CPU runs from the subclock.

Top module: `wdi_timer`

## Requirements
- R1: In interval role with the mask clear, consecutive `irq_pulse` pulses are spaced exactly 2^(PRE_W+e) clock cycles apart, where e is the tap exponent chosen by the period select.
- R2: A write with `cfg_wd_mode`=1 selects watchdog role. After that, writes with `cfg_wd_mode`=0 leave the block in watchdog role. Only `rst_n` low returns it to interval role, and both outputs are 0 during reset.
- R3: The period select `cfg_sel` maps codes 0..6 to tap exponents e=4..10 and code 7 to e=12. With the default PRE_W=10 this gives periods of 2^14 through 2^20 and 2^22 cycles.
- R4: While `irq_mask` is 1, an elapsed period produces no `irq_pulse`, but the next period still starts at that point. So with one period masked, the next pulse comes two periods after the last one.
- R5: A write with `cfg_run`=1 clears the main counter and starts counting. After reset and before the first such write, no pulse appears on either output.
- R6: `halt_req` has no effect on the count. While `idle_req` or `stop_req` is 1, the count is frozen, so a freeze of F cycles stretches the period in progress by exactly F cycles.
- R7: While `cpu_on_subclk` is 1, the count holds its value and later resumes from it, stretching the period in progress by the time spent frozen.
- R8: A restart does not clear the prescaler. The first pulse after a restart write comes between (2^e-1)*2^PRE_W+1 and 2^e*2^PRE_W cycles after the write edge.
- R9: In watchdog role an elapsed period raises a one-cycle `wd_overflow` and never `irq_pulse`. Restart writes made less than one period apart prevent any overflow.
- R10: Each `irq_pulse` and each `wd_overflow` is high for exactly one cycle, and the count restarts from zero after it.
- R11: A write with `cfg_run`=0 does not disturb the count in progress. A role-bit write of 0 in watchdog role leaves the overflow spacing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the three configuration fields |
| cfg_wd_mode | input | 1 | Role bit: 1 selects watchdog role (one-way) |
| cfg_sel | input | 3 | Period select code |
| cfg_run | input | 1 | 1 clears the main counter and starts counting |
| halt_req | input | 1 | Halt power mode (counting continues) |
| idle_req | input | 1 | Idle power mode (count frozen) |
| stop_req | input | 1 | Stop power mode (count frozen) |
| cpu_on_subclk | input | 1 | CPU clocked from the subclock (count frozen) |
| irq_mask | input | 1 | Mask for the interval interrupt |
| irq_pulse | output | 1 | One-cycle interval interrupt request |
| wd_overflow | output | 1 | One-cycle watchdog overflow event |

## Verification
The assertions assume that the power-mode and subclock inputs are level signals sampled on the clock, and that a configuration write lasts exactly one cycle. They also assume that the selected period is longer than two cycles, so that a pulse can never be followed straight away by another. The stimulus changes every input only on the falling edge. It holds the strobe for one cycle per write, and it keeps each freeze shorter than a period. It also issues restarts only just after a pulse, so that no write lands on the cycle where a period ends.

// File: rtl/wdi_pkg.sv
package wdi_pkg;

    localparam int SEL_W = 3;

    // tap exponent above the prescaler: codes 0..6 -> 4..10, code 7 -> 12
    function automatic int unsigned tap_exp(input logic [SEL_W-1:0] code);
        int unsigned e;
        if (code == SEL_W'(7)) e = 12;
        else                   e = 32'(code) + 4;
        return e;
    endfunction

    typedef struct packed {
        logic             wd_mode;
        logic [SEL_W-1:0] sel;
        logic             running;
        logic             irq;
        logic             ovf;
    } ctl_t;

endpackage

// File: rtl/wdi_prescaler.sv
module wdi_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = adv & (&pre_q.cnt);
        if (adv) pre_d.cnt = pre_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R6/R7: a frozen clock domain keeps the prescaler phase
    p_pre_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pre_q.cnt));

endmodule

// File: rtl/wdi_interval_ctr.sv
module wdi_interval_ctr
    import wdi_pkg::*;
#(
    parameter int MAIN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    typedef struct packed {
        logic [MAIN_W-1:0] cnt;
    } main_t;

    main_t             main_d, main_q;
    logic [MAIN_W-1:0] low_mask;

    always_comb begin
        low_mask = (MAIN_W'(1) << tap_exp(sel)) - MAIN_W'(1);
        expire   = tick & ~clr & ((main_q.cnt & low_mask) == low_mask);
        main_d   = main_q;
        if (clr || expire) main_d.cnt = '0;
        else if (tick)     main_d.cnt = main_q.cnt + MAIN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) main_q <= '0;
        else        main_q <= main_d;
    end

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (main_q.cnt == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(main_q.cnt));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (main_q.cnt == '0));

endmodule

// File: rtl/wdi_timer.sv
module wdi_timer
    import wdi_pkg::*;
#(
    parameter int PRE_W  = 10,
    parameter int MAIN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_wd_mode,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_run,
    input  logic             halt_req,
    input  logic             idle_req,
    input  logic             stop_req,
    input  logic             cpu_on_subclk,
    input  logic             irq_mask,
    output logic             irq_pulse,
    output logic             wd_overflow
);

    ctl_t ctl_d, ctl_q;
    logic pre_adv, pre_tick, main_tick, main_clr, expire;

    // halt leaves the clock running; idle, stop and subclock freeze it
    assign pre_adv   = ~(idle_req | stop_req | cpu_on_subclk);
    assign main_tick = pre_tick & ctl_q.running;
    assign main_clr  = cfg_we & cfg_run;

    wdi_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pre_adv),
        .tick  (pre_tick)
    );

    wdi_interval_ctr #(.MAIN_W(MAIN_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (main_tick),
        .clr    (main_clr),
        .sel    (ctl_q.sel),
        .expire (expire)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = expire & ~ctl_q.wd_mode & ~irq_mask;
        ctl_d.ovf = expire & ctl_q.wd_mode;
        if (cfg_we) begin
            ctl_d.wd_mode = ctl_q.wd_mode | cfg_wd_mode;
            ctl_d.sel     = cfg_sel;
            if (cfg_run) ctl_d.running = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_pulse   = ctl_q.irq;
    assign wd_overflow = ctl_q.ovf;

    p_mode_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wd_mode |=> ctl_q.wd_mode);

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(irq_mask));

    p_halt_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !idle_req && !stop_req && !cpu_on_subclk) |-> pre_adv);

    p_no_irq_wd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_q.wd_mode) |-> !irq_pulse);

    p_ovf_wd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_overflow |-> ctl_q.wd_mode);

    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_ovf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_overflow |=> !wd_overflow);

    p_idle_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.running |-> (!irq_pulse && !wd_overflow));

endmodule

// File: tb/sim_wdi_timer.sv
module sim_wdi_timer;

    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_wd_mode = 1'b0, cfg_run = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       halt_req = 1'b0, idle_req = 1'b0, stop_req = 1'b0;
    logic       cpu_on_subclk = 1'b0, irq_mask = 1'b0;
    logic       irq_pulse, wd_overflow;

    always #4 clk = ~clk;

    wdi_timer #(.PRE_W(P), .MAIN_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wd_mode(cfg_wd_mode),
        .cfg_sel(cfg_sel), .cfg_run(cfg_run), .halt_req(halt_req),
        .idle_req(idle_req), .stop_req(stop_req), .cpu_on_subclk(cpu_on_subclk),
        .irq_mask(irq_mask), .irq_pulse(irq_pulse), .wd_overflow(wd_overflow)
    );

    typedef struct {
        bit    is_ovf;
        int    lo;
        int    hi;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errors = 0;
    int   cyc = 0, ref_cyc = 0, pulses = 0;
    bit   mark_pending = 1'b0, prev_hi = 1'b0;

    function automatic int per(int e);
        return 1 << (P + e);
    endfunction

    // monitor: pops one expected item per pulse and checks its spacing
    always @(negedge clk) begin
        cyc++;
        if (mark_pending) begin
            ref_cyc = cyc;
            mark_pending = 1'b0;
        end
        if (rst_n && (irq_pulse || wd_overflow)) begin
            if (prev_hi) begin
                checks++; errors++;
                $display("FAIL R10 pulse width: high again at cycle %0d, expected 1-cycle pulse", cyc);
            end else begin
                pulses++;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected pulse irq=%0b ovf=%0b gap=%0d, expected none",
                             irq_pulse, wd_overflow, cyc - ref_cyc);
                end else begin
                    exp_t it;
                    int   gap;
                    it  = q.pop_front();
                    gap = cyc - ref_cyc;
                    if (wd_overflow !== it.is_ovf || irq_pulse === it.is_ovf) begin
                        errors++;
                        $display("FAIL %s kind: irq=%0b ovf=%0b, expected ovf=%0b",
                                 it.req, irq_pulse, wd_overflow, it.is_ovf);
                    end else if (gap < it.lo || gap > it.hi) begin
                        errors++;
                        $display("FAIL %s gap: actual %0d, expected %0d..%0d",
                                 it.req, gap, it.lo, it.hi);
                    end
                end
                ref_cyc = cyc;
            end
        end
        prev_hi = rst_n && (irq_pulse || wd_overflow);
    end

    task automatic push(bit ovf, int lo, int hi, string r);
        exp_t it;
        it.is_ovf = ovf; it.lo = lo; it.hi = hi; it.req = r;
        q.push_back(it);
    endtask

    task automatic cfg_write(bit mode, bit [2:0] sel, bit run);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wd_mode = mode; cfg_sel = sel; cfg_run = run;
        @(posedge clk);
        if (run) mark_pending = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wd_mode = 1'b0; cfg_run = 1'b0;
    endtask

    task automatic drain();
        int w = 0;
        while (q.size() != 0 && w < 40000) begin
            @(negedge clk);
            w++;
        end
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL %s missing pulse: actual none after %0d cycles, expected %0d..%0d",
                     q[0].req, w, q[0].lo, q[0].hi);
            q.delete();
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (irq_pulse !== 1'b0 || wd_overflow !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset outputs: actual %0b%0b, expected 00", irq_pulse, wd_overflow);
        end
        rst_n = 1'b1;

        // R5: no pulses before the first restart write
        repeat (300) @(negedge clk);
        checks++;
        if (pulses != 0) begin
            errors++;
            $display("FAIL R5 idle before run: actual %0d pulses, expected 0", pulses);
        end

        // R8 first window, R1 steady spacing (code 0, e=4)
        cfg_write(1'b0, 3'd0, 1'b1);
        push(1'b0, (per(4) - (1 << P)) + 1, per(4), "R8");
        for (int i = 0; i < 3; i++) push(1'b0, per(4), per(4), "R1");
        drain();

        // R4: one masked period doubles the gap
        irq_mask = 1'b1;
        push(1'b0, 2 * per(4), 2 * per(4), "R4");
        repeat (per(4) + 6) @(negedge clk);
        irq_mask = 1'b0;
        drain();

        // R6: halt does not change the spacing
        halt_req = 1'b1;
        push(1'b0, per(4), per(4), "R6 halt");
        drain();
        halt_req = 1'b0;

        // R6: idle freeze stretches by 30
        push(1'b0, per(4) + 30, per(4) + 30, "R6 idle");
        repeat (10) @(negedge clk);
        idle_req = 1'b1;
        repeat (30) @(negedge clk);
        idle_req = 1'b0;
        drain();

        // R6: stop freeze stretches by 20
        push(1'b0, per(4) + 20, per(4) + 20, "R6 stop");
        repeat (12) @(negedge clk);
        stop_req = 1'b1;
        repeat (20) @(negedge clk);
        stop_req = 1'b0;
        drain();

        // R7: subclock freeze holds and resumes
        push(1'b0, per(4) + 25, per(4) + 25, "R7");
        repeat (15) @(negedge clk);
        cpu_on_subclk = 1'b1;
        repeat (25) @(negedge clk);
        cpu_on_subclk = 1'b0;
        drain();

        // R3: code 3 (e=7), code 7 (e=12), code 1 (e=5)
        cfg_write(1'b0, 3'd3, 1'b1);
        push(1'b0, (per(7) - (1 << P)) + 1, per(7), "R3 code3 first");
        push(1'b0, per(7), per(7), "R3 code3");
        drain();
        cfg_write(1'b0, 3'd7, 1'b1);
        push(1'b0, (per(12) - (1 << P)) + 1, per(12), "R3 code7");
        drain();
        cfg_write(1'b0, 3'd1, 1'b1);
        push(1'b0, (per(5) - (1 << P)) + 1, per(5), "R3 code1");
        push(1'b0, per(5), per(5), "R1 code1");
        drain();

        // R9: watchdog role, overflow spacing
        cfg_write(1'b1, 3'd1, 1'b1);
        push(1'b1, (per(5) - (1 << P)) + 1, per(5), "R9 first");
        push(1'b1, per(5), per(5), "R9");
        drain();

        // R9: periodic restarts prevent overflow
        for (int i = 0; i < 5; i++) begin
            repeat (90) @(negedge clk);
            cfg_write(1'b1, 3'd1, 1'b1);
        end
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R9 queue: actual %0d items, expected 0", q.size());
        end
        push(1'b1, (per(5) - (1 << P)) + 1, per(5), "R9 after kicks");
        drain();

        // R2/R11: role bit 0 ignored, run 0 keeps the count
        repeat (30) @(negedge clk);
        cfg_write(1'b0, 3'd1, 1'b0);
        push(1'b1, per(5), per(5), "R11");
        push(1'b1, per(5), per(5), "R2");
        drain();

        // R2: reset restores interval role
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (irq_pulse !== 1'b0 || wd_overflow !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset outputs: actual %0b%0b, expected 00", irq_pulse, wd_overflow);
        end
        rst_n = 1'b1;
        cfg_write(1'b0, 3'd0, 1'b1);
        push(1'b0, (per(4) - (1 << P)) + 1, per(4), "R2 after reset");
        drain();

        finish_run();
    end

endmodule